// File: doc/BRIEF.md
# CAN Basic-Mode Transmit/Receive Buffer Controller

This block couples a host register interface to a CAN protocol engine when no message RAM and no acceptance filtering are wanted. A single transmit register set holds one outgoing frame (identifier, DLC and payload). Once the host sets the transmit BUSY flag, that set is locked against host writes. When the engine reports an idle bus, the set is handed over with a one-cycle start pulse. If the engine reports lost arbitration or an error, the frame is offered again at the next idle bus. A successful completion, or a host abort, releases the lock.

A single receive register set takes a copy of the engine's shift word at the end of every frame. There is no filtering of any kind. NEWDAT and MSGLST flags track whether the host has taken the previous frame. The host can also request a copy of the live shift word at any moment, including while a frame is still being shifted. This is useful for watching a transfer in progress.

In this mode the command message-number and command-mask fields have no meaning. The host wait/ready line is held inactive permanently.

Top module: `canbuf_basic`

## Requirements
- R1: After reset, tx_busy = 0, tx_start = 0, rx_frame = 0 and rx_ctrl = 0.
- R2: A tx command write with tx_cmd_busy = 1 while tx_busy = 0 makes tx_busy = 1 after that edge. While tx_busy = 1, writes to the transmit data registers leave tx_frame unchanged.
- R3: While tx_busy = 1 and no frame is in flight, an edge that samples bus_idle = 1 produces a single-cycle tx_start = 1 after that edge. tx_frame = {id, dlc, data}, with the identifier in the top ID_W bits, the DLC in bits [DATA_W+3:DATA_W] and the payload in bits [DATA_W-1:0]. With bus_idle = 0 no tx_start appears.
- R4: tx_done while a frame is in flight clears tx_busy after that edge, and transmit data writes take effect again.
- R5: tx_error or arb_lost while a frame is in flight, without an abort, keeps tx_busy = 1 with no tx_start on that edge. The next edge that samples bus_idle = 1 issues tx_start again.
- R6: A tx command write with tx_cmd_busy = 0 while tx_busy = 1 clears tx_busy after that edge and suppresses a tx_start on that same edge. Later tx_error, arb_lost or tx_done pulses cause no new tx_start.
- R7: rx_done copies shift_word into rx_frame and sets NEWDAT (rx_ctrl bit 15), whatever the identifier.
- R8: rx_done while NEWDAT = 1 and rx_ack = 0 sets MSGLST (rx_ctrl bit 14). rx_ack clears both flags. When rx_done and rx_ack coincide, the result is NEWDAT = 1 and MSGLST = 0.
- R9: An rx command write with rx_cmd_busy = 1 copies shift_word into rx_frame without rx_done and leaves NEWDAT and MSGLST unchanged. An rx command write with rx_cmd_busy = 0 copies nothing.
- R10: rx_ctrl[3:0] shows the DLC held in rx_frame bits [DATA_W+3:DATA_W]. All rx_ctrl bits other than 15, 14 and 3:0 read 0.
- R11: The tx_cmd_num, tx_cmd_mask, rx_cmd_num and rx_cmd_mask inputs have no effect on any output.
- R12: host_wait_n is 1 in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_wr_en | input | 1 | Write strobe for the transmit data registers |
| tx_wr_id | input | ID_W | Identifier to write |
| tx_wr_dlc | input | 4 | DLC to write |
| tx_wr_data | input | DATA_W | Payload to write |
| tx_cmd_wr | input | 1 | Transmit command register write strobe |
| tx_cmd_busy | input | 1 | BUSY value carried by the transmit command write |
| tx_cmd_num | input | 6 | Message number field (ignored) |
| tx_cmd_mask | input | 8 | Command mask field (ignored) |
| rx_cmd_wr | input | 1 | Receive command register write strobe |
| rx_cmd_busy | input | 1 | BUSY value carried by the receive command write |
| rx_cmd_num | input | 6 | Message number field (ignored) |
| rx_cmd_mask | input | 8 | Command mask field (ignored) |
| rx_ack | input | 1 | Host has taken the receive buffer |
| bus_idle | input | 1 | Engine reports an idle bus |
| tx_done | input | 1 | Engine completed the frame |
| tx_error | input | 1 | Engine aborted the frame on an error |
| arb_lost | input | 1 | Engine lost arbitration |
| rx_done | input | 1 | Engine finished receiving a frame |
| shift_word | input | ID_W+4+DATA_W | Live engine shift register |
| tx_busy | output | 1 | Transmit BUSY / lock state |
| tx_start | output | 1 | One-cycle load-and-send pulse to the engine |
| tx_frame | output | ID_W+4+DATA_W | Locked transmit word |
| rx_frame | output | ID_W+4+DATA_W | Receive buffer contents |
| rx_ctrl | output | 16 | Receive control word: NEWDAT, MSGLST, DLC |
| host_wait_n | output | 1 | Host wait/ready, held at 1 |

## Verification
The hardest state to reach is an abort that lands while a frame is in flight with the engine's report still outstanding. Only there does the difference between "clear BUSY" and "also forbid the reload" become visible. The stimulus reaches it by running a full start, writing BUSY = 0 before any engine report, and then firing tx_error, arb_lost or tx_done with bus_idle held high for several cycles. The bench also lands an abort on the very edge where bus_idle would otherwise trigger a load.

// File: rtl/canbuf_pkg.sv
package canbuf_pkg;

  typedef enum logic [1:0] {
    TXS_IDLE = 2'd0,
    TXS_WAIT = 2'd1,
    TXS_FLY  = 2'd2
  } txs_e;

  localparam int CTRL_W     = 16;
  localparam int NEWDAT_BIT = 15;
  localparam int MSGLST_BIT = 14;

  // Receive control word assembly: flags and DLC, everything else zero.
  function automatic logic [CTRL_W-1:0] make_ctrl(input logic nd, input logic ml,
                                                  input logic [3:0] dlc);
    logic [CTRL_W-1:0] w;
    w             = '0;
    w[NEWDAT_BIT] = nd;
    w[MSGLST_BIT] = ml;
    w[3:0]        = dlc;
    return w;
  endfunction

  // Flag update: returns {newdat, msglst}.
  function automatic logic [1:0] next_flags(input logic nd, input logic ml,
                                            input logic store, input logic ack);
    logic [1:0] r;
    if (store)    r = {1'b1, (nd | ml) & ~ack};
    else if (ack) r = 2'b00;
    else          r = {nd, ml};
    return r;
  endfunction

endpackage

// File: rtl/canbuf_txctl.sv
module canbuf_txctl
  import canbuf_pkg::*;
#(
  parameter int ID_W   = 11,
  parameter int DATA_W = 64,
  localparam int FRAME_W = ID_W + 4 + DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ID_W-1:0]    wr_id,
  input  logic [3:0]         wr_dlc,
  input  logic [DATA_W-1:0]  wr_data,
  input  logic               cmd_wr,
  input  logic               cmd_busy,
  input  logic               bus_idle,
  input  logic               done,
  input  logic               err,
  input  logic               arb_lost,
  output logic               busy,
  output logic               start,
  output logic [FRAME_W-1:0] frame,
  output logic               set_ev,
  output logic               load_ev,
  output logic               abort_ev,
  output logic               retry_ev,
  output logic               finish_ev
);

  txs_e              state_q, state_d;
  logic              start_q;
  logic [ID_W-1:0]   id_q;
  logic [3:0]        dlc_q;
  logic [DATA_W-1:0] data_q;
  logic              locked;

  assign locked    = (state_q != TXS_IDLE);
  assign set_ev    = cmd_wr &  cmd_busy & ~locked;
  assign abort_ev  = cmd_wr & ~cmd_busy &  locked;
  assign load_ev   = (state_q == TXS_WAIT) & bus_idle & ~abort_ev;
  assign finish_ev = (state_q == TXS_FLY) & done & ~abort_ev;
  assign retry_ev  = (state_q == TXS_FLY) & ~done & (err | arb_lost) & ~abort_ev;

  always_comb begin
    state_d = state_q;
    if (abort_ev)       state_d = TXS_IDLE;
    else if (set_ev)    state_d = TXS_WAIT;
    else if (load_ev)   state_d = TXS_FLY;
    else if (finish_ev) state_d = TXS_IDLE;
    else if (retry_ev)  state_d = TXS_WAIT;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= TXS_IDLE;
      start_q <= 1'b0;
    end else begin
      state_q <= state_d;
      start_q <= load_ev;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      id_q   <= '0;
      dlc_q  <= '0;
      data_q <= '0;
    end else if (wr_en && !locked) begin
      id_q   <= wr_id;
      dlc_q  <= wr_dlc;
      data_q <= wr_data;
    end
  end

  assign busy  = locked;
  assign start = start_q;
  assign frame = {id_q, dlc_q, data_q};

endmodule

// File: rtl/canbuf_rxbuf.sv
module canbuf_rxbuf
  import canbuf_pkg::*;
#(
  parameter int FRAME_W = 79,
  parameter int DATA_W  = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frame_end,
  input  logic               snap_req,
  input  logic               ack,
  input  logic [FRAME_W-1:0] shift_word,
  output logic [FRAME_W-1:0] frame,
  output logic [CTRL_W-1:0]  ctrl,
  output logic               store_ev,
  output logic               snap_ev,
  output logic               overrun_ev
);

  logic [FRAME_W-1:0] frame_q;
  logic               nd_q, ml_q;
  logic [1:0]         flags_d;

  assign store_ev   = frame_end;
  assign snap_ev    = snap_req;
  assign overrun_ev = frame_end & nd_q & ~ack;
  assign flags_d    = next_flags(nd_q, ml_q, store_ev, ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= '0;
      nd_q    <= 1'b0;
      ml_q    <= 1'b0;
    end else begin
      if (store_ev || snap_ev) frame_q <= shift_word;
      nd_q <= flags_d[1];
      ml_q <= flags_d[0];
    end
  end

  assign frame = frame_q;
  assign ctrl  = make_ctrl(nd_q, ml_q, frame_q[DATA_W+3:DATA_W]);

endmodule

// File: rtl/canbuf_basic.sv
module canbuf_basic
  import canbuf_pkg::*;
#(
  parameter int ID_W   = 11,
  parameter int DATA_W = 64,
  localparam int FRAME_W = ID_W + 4 + DATA_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tx_wr_en,
  input  logic [ID_W-1:0]    tx_wr_id,
  input  logic [3:0]         tx_wr_dlc,
  input  logic [DATA_W-1:0]  tx_wr_data,
  input  logic               tx_cmd_wr,
  input  logic               tx_cmd_busy,
  input  logic [5:0]         tx_cmd_num,
  input  logic [7:0]         tx_cmd_mask,
  input  logic               rx_cmd_wr,
  input  logic               rx_cmd_busy,
  input  logic [5:0]         rx_cmd_num,
  input  logic [7:0]         rx_cmd_mask,
  input  logic               rx_ack,
  input  logic               bus_idle,
  input  logic               tx_done,
  input  logic               tx_error,
  input  logic               arb_lost,
  input  logic               rx_done,
  input  logic [FRAME_W-1:0] shift_word,
  output logic               tx_busy,
  output logic               tx_start,
  output logic [FRAME_W-1:0] tx_frame,
  output logic [FRAME_W-1:0] rx_frame,
  output logic [CTRL_W-1:0]  rx_ctrl,
  output logic               host_wait_n
);

  logic tx_set_ev, tx_load_ev, tx_abort_ev, tx_retry_ev, tx_finish_ev;
  logic rx_store_ev, rx_snap_ev, rx_overrun_ev;
  logic rx_snap_req;
  logic unused_cmd_fields;

  // Command fields carry no meaning in this mode.
  assign unused_cmd_fields = ^{tx_cmd_num, tx_cmd_mask, rx_cmd_num, rx_cmd_mask};

  assign rx_snap_req = rx_cmd_wr & rx_cmd_busy;
  assign host_wait_n = 1'b1;

  canbuf_txctl #(.ID_W(ID_W), .DATA_W(DATA_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (tx_wr_en),
    .wr_id     (tx_wr_id),
    .wr_dlc    (tx_wr_dlc),
    .wr_data   (tx_wr_data),
    .cmd_wr    (tx_cmd_wr),
    .cmd_busy  (tx_cmd_busy),
    .bus_idle  (bus_idle),
    .done      (tx_done),
    .err       (tx_error),
    .arb_lost  (arb_lost),
    .busy      (tx_busy),
    .start     (tx_start),
    .frame     (tx_frame),
    .set_ev    (tx_set_ev),
    .load_ev   (tx_load_ev),
    .abort_ev  (tx_abort_ev),
    .retry_ev  (tx_retry_ev),
    .finish_ev (tx_finish_ev)
  );

  canbuf_rxbuf #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) u_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_end  (rx_done),
    .snap_req   (rx_snap_req),
    .ack        (rx_ack),
    .shift_word (shift_word),
    .frame      (rx_frame),
    .ctrl       (rx_ctrl),
    .store_ev   (rx_store_ev),
    .snap_ev    (rx_snap_ev),
    .overrun_ev (rx_overrun_ev)
  );

endmodule

// File: rtl/canbuf_chk.sv
module canbuf_chk
  import canbuf_pkg::*;
#(
  parameter int FRAME_W = 79
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_idle,
  input logic               tx_cmd_wr,
  input logic               tx_cmd_busy,
  input logic               tx_busy,
  input logic               tx_start,
  input logic [FRAME_W-1:0] tx_frame,
  input logic               tx_set_ev,
  input logic               tx_retry_ev,
  input logic               tx_finish_ev,
  input logic               rx_done,
  input logic               rx_ack,
  input logic               rx_snap_ev,
  input logic               rx_overrun_ev,
  input logic [FRAME_W-1:0] shift_word,
  input logic [FRAME_W-1:0] rx_frame,
  input logic [CTRL_W-1:0]  rx_ctrl
);

  // R2
  set_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_set_ev |=> tx_busy);

  // R2
  lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tx_busy) |-> $stable(tx_frame));

  // R3
  start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |-> ($past(bus_idle) && $past(tx_busy) && tx_busy));

  // R4
  finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_finish_ev |=> !tx_busy);

  // R5
  retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_retry_ev |=> (tx_busy && !tx_start));

  // R6
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_cmd_wr && !tx_cmd_busy && tx_busy) |=> (!tx_busy && !tx_start));

  // R7
  store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> (rx_ctrl[NEWDAT_BIT] && rx_frame == $past(shift_word)));

  // R8
  overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun_ev |=> rx_ctrl[MSGLST_BIT]);

  // R8
  ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ack && !rx_done) |=> (!rx_ctrl[NEWDAT_BIT] && !rx_ctrl[MSGLST_BIT]));

  // R9
  snap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_snap_ev && !rx_done && !rx_ack) |=>
      (rx_frame == $past(shift_word) && $stable(rx_ctrl[NEWDAT_BIT]) && $stable(rx_ctrl[MSGLST_BIT])));

endmodule

bind canbuf_basic canbuf_chk #(.FRAME_W(FRAME_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .bus_idle      (bus_idle),
  .tx_cmd_wr     (tx_cmd_wr),
  .tx_cmd_busy   (tx_cmd_busy),
  .tx_busy       (tx_busy),
  .tx_start      (tx_start),
  .tx_frame      (tx_frame),
  .tx_set_ev     (tx_set_ev),
  .tx_retry_ev   (tx_retry_ev),
  .tx_finish_ev  (tx_finish_ev),
  .rx_done       (rx_done),
  .rx_ack        (rx_ack),
  .rx_snap_ev    (rx_snap_ev),
  .rx_overrun_ev (rx_overrun_ev),
  .shift_word    (shift_word),
  .rx_frame      (rx_frame),
  .rx_ctrl       (rx_ctrl)
);

// File: tb/sim_canbuf_basic.sv
`timescale 1ns/1ps
module sim_canbuf_basic;

  localparam int ID_W    = 11;
  localparam int DATA_W  = 64;
  localparam int FRAME_W = ID_W + 4 + DATA_W;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic               tx_wr_en = 0, tx_cmd_wr = 0, tx_cmd_busy = 0;
  logic [ID_W-1:0]    tx_wr_id = '0;
  logic [3:0]         tx_wr_dlc = '0;
  logic [DATA_W-1:0]  tx_wr_data = '0;
  logic [5:0]         tx_cmd_num = '0, rx_cmd_num = '0;
  logic [7:0]         tx_cmd_mask = '0, rx_cmd_mask = '0;
  logic               rx_cmd_wr = 0, rx_cmd_busy = 0, rx_ack = 0;
  logic               bus_idle = 0, tx_done = 0, tx_error = 0, arb_lost = 0, rx_done = 0;
  logic [FRAME_W-1:0] shift_word = '0;
  logic               tx_busy, tx_start, host_wait_n;
  logic [FRAME_W-1:0] tx_frame, rx_frame;
  logic [15:0]        rx_ctrl;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  canbuf_basic #(.ID_W(ID_W), .DATA_W(DATA_W)) u0 (.*);

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [FRAME_W-1:0] pack(input logic [ID_W-1:0] id, input logic [3:0] dlc,
                                              input logic [DATA_W-1:0] d);
    return {id, dlc, d};
  endfunction

  function automatic logic [15:0] ctrl_exp(input logic nd, input logic ml, input logic [3:0] dlc);
    return (16'(nd) << 15) | (16'(ml) << 14) | 16'(dlc);
  endfunction

  task automatic wr_regs(input logic [ID_W-1:0] id, input logic [3:0] dlc, input logic [DATA_W-1:0] d);
    tx_wr_en = 1; tx_wr_id = id; tx_wr_dlc = dlc; tx_wr_data = d;
    step();
    tx_wr_en = 0;
  endtask

  task automatic tx_cmd(input logic b, input logic [5:0] num, input logic [7:0] mask);
    tx_cmd_wr = 1; tx_cmd_busy = b; tx_cmd_num = num; tx_cmd_mask = mask;
    step();
    tx_cmd_wr = 0;
  endtask

  task automatic rx_cmd(input logic b, input logic [5:0] num, input logic [7:0] mask);
    rx_cmd_wr = 1; rx_cmd_busy = b; rx_cmd_num = num; rx_cmd_mask = mask;
    step();
    rx_cmd_wr = 0;
  endtask

  task automatic rx_frame_in(input logic [FRAME_W-1:0] w, input logic with_ack);
    shift_word = w; rx_done = 1; rx_ack = with_ack;
    step();
    rx_done = 0; rx_ack = 0;
  endtask

  task automatic pulse_ack();
    rx_ack = 1;
    step();
    rx_ack = 0;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 50000 && !finished) begin
      finished = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=<50000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [FRAME_W-1:0] fa, fb, fw;
    int starts;

    // R1 reset state
    step(); step();
    chk("R1 tx_busy", tx_busy, 0);
    chk("R1 tx_start", tx_start, 0);
    chk("R1 rx_frame", rx_frame, 0);
    chk("R1 rx_ctrl", rx_ctrl, 0);
    chk("R12 wait in reset", host_wait_n, 1);
    rst_n = 1;
    step();

    // R11: BUSY=0 with arbitrary fields while idle does nothing
    tx_cmd(0, 6'h3f, 8'hff);
    chk("R11 idle clear", tx_busy, 0);

    // R2 lock
    fa = pack(11'h5a3, 4'd8, 64'h0123_4567_89ab_cdef);
    fb = pack(11'h0f1, 4'd2, 64'hdead_beef_0000_1111);
    wr_regs(11'h5a3, 4'd8, 64'h0123_4567_89ab_cdef);
    chk("R2 unlocked write", tx_frame, fa);
    tx_cmd(1, 6'h15, 8'ha5);
    chk("R2 busy set", tx_busy, 1);
    wr_regs(11'h0f1, 4'd2, 64'hdead_beef_0000_1111);
    chk("R2 locked write ignored", tx_frame, fa);

    // R3 no start without idle bus
    for (int i = 0; i < 3; i++) begin
      step();
      chk("R3 no start while bus busy", tx_start, 0);
    end
    bus_idle = 1;
    step();
    chk("R3 start pulse", tx_start, 1);
    chk("R3 frame layout", tx_frame, fa);
    bus_idle = 0;
    step();
    chk("R3 single pulse", tx_start, 0);
    tx_done = 1;
    step();
    tx_done = 0;
    chk("R4 done clears busy", tx_busy, 0);
    wr_regs(11'h0f1, 4'd2, 64'hdead_beef_0000_1111);
    chk("R4 unlocked after done", tx_frame, fb);

    // R5 retry sweep over error kinds and repeat counts
    for (int kind = 0; kind < 2; kind++) begin
      for (int reps = 1; reps <= 3; reps++) begin
        starts = 0;
        tx_cmd(1, 6'(reps), 8'(kind));
        bus_idle = 1;
        step();
        starts += int'(tx_start);
        for (int r = 0; r < reps; r++) begin
          if (kind == 0) tx_error = 1; else arb_lost = 1;
          step();
          tx_error = 0; arb_lost = 0;
          chk("R5 busy kept after fail", tx_busy, 1);
          chk("R5 no start on fail edge", tx_start, 0);
          step();
          starts += int'(tx_start);
        end
        bus_idle = 0;
        chk("R5 reload count", starts, reps + 1);
        tx_done = 1;
        step();
        tx_done = 0;
        chk("R5 done after retries", tx_busy, 0);
      end
    end

    // R6 abort while waiting
    tx_cmd(1, 0, 0);
    tx_cmd(0, 6'h2a, 8'h3c);
    chk("R6 abort in wait", tx_busy, 0);
    bus_idle = 1;
    starts = 0;
    for (int i = 0; i < 3; i++) begin
      step();
      starts += int'(tx_start);
    end
    chk("R6 no start after wait abort", starts, 0);
    bus_idle = 0;

    // R6 abort on the same edge that sees an idle bus
    tx_cmd(1, 0, 0);
    bus_idle = 1;
    tx_cmd(0, 0, 0);
    chk("R6 abort beats load", tx_start, 0);
    chk("R6 abort beats load busy", tx_busy, 0);
    bus_idle = 0;

    // R6 abort in flight followed by each engine report
    for (int kind = 0; kind < 3; kind++) begin
      tx_cmd(1, 0, 0);
      bus_idle = 1;
      step();
      chk("R6 in-flight start", tx_start, 1);
      bus_idle = 0;
      tx_cmd(0, 0, 0);
      chk("R6 abort in flight", tx_busy, 0);
      bus_idle = 1;
      if (kind == 0) tx_error = 1; else if (kind == 1) arb_lost = 1; else tx_done = 1;
      step();
      tx_error = 0; arb_lost = 0; tx_done = 0;
      starts = int'(tx_start);
      for (int i = 0; i < 3; i++) begin
        step();
        starts += int'(tx_start);
      end
      chk("R6 no reload after abort", starts, 0);
      chk("R6 stays idle", tx_busy, 0);
      bus_idle = 0;
    end

    // R7 / R10 / R8 receive sweep over every DLC and spread identifiers
    for (int d = 0; d < 16; d++) begin
      logic [ID_W-1:0] id;
      id = (d == 15) ? '1 : ID_W'(d * 131);
      fw = pack(id, 4'(d), {32'(d * 977), 32'(~d)});
      rx_frame_in(fw, 0);
      chk("R7 stored frame", rx_frame, fw);
      chk("R10 ctrl after store", rx_ctrl, ctrl_exp(1, 0, 4'(d)));
      pulse_ack();
      chk("R8 ack clears flags", rx_ctrl, ctrl_exp(0, 0, 4'(d)));
    end

    // R8 overrun, then coincident store+ack
    fa = pack(11'h111, 4'd3, 64'h1);
    fb = pack(11'h222, 4'd5, 64'h2);
    rx_frame_in(fa, 0);
    rx_frame_in(fb, 0);
    chk("R8 overwrite frame", rx_frame, fb);
    chk("R8 msglst set", rx_ctrl, ctrl_exp(1, 1, 4'd5));
    fw = pack(11'h333, 4'd7, 64'h3);
    rx_frame_in(fw, 1);
    chk("R8 store with ack", rx_ctrl, ctrl_exp(1, 0, 4'd7));
    pulse_ack();
    chk("R8 ack after", rx_ctrl, ctrl_exp(0, 0, 4'd7));

    // R9 snapshot without rx_done, flags untouched; R11 fields ignored
    fw = pack(11'h4c4, 4'd9, 64'hfeed_face_cafe_0001);
    shift_word = fw;
    rx_cmd(1, 6'h3f, 8'hff);
    chk("R9 snapshot frame", rx_frame, fw);
    chk("R9 snapshot flags", rx_ctrl, ctrl_exp(0, 0, 4'd9));
    shift_word = pack(11'h001, 4'd1, 64'h77);
    rx_cmd(0, 6'h01, 8'h01);
    chk("R9 no copy on busy=0", rx_frame, fw);
    chk("R11 rx fields ignored", rx_ctrl, ctrl_exp(0, 0, 4'd9));
    rx_frame_in(fa, 0);
    fw = pack(11'h0aa, 4'd12, 64'h55);
    shift_word = fw;
    rx_cmd(1, 0, 0);
    chk("R9 snapshot keeps newdat", rx_ctrl, ctrl_exp(1, 0, 4'd12));

    chk("R12 wait after run", host_wait_n, 1);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule